// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Pipeline

This block is the control side of exception handling for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It keeps a small shadow pipeline that tracks, for each instruction in flight, whether it is valid, its PC, and whether a fault has been flagged against it. Fetch can flag an instruction address fault. Decode can flag an illegal opcode. Execute can flag an arithmetic overflow. The memory stage can flag a data address fault. None of these faults is acted on where it is raised. Each one rides along with its instruction until the instruction reaches the memory stage, which is the single commit point.

At commit the controller resolves by priority what, if anything, to take. An external interrupt, when enabled, beats every synchronous fault. Among the faults of one instruction, the one from the earliest stage wins. When something is taken, the controller does the following:
- records a cause code and the PC of the committing instruction;
- discards all younger instructions and stops writeback of the faulting one;
- steers fetch to a fixed handler address;
- enters kernel mode with interrupts disabled.

A return-from-exception pulse re-enables interrupts and brings back the mode that was active before the latest entry.

Top module: `pexc_ctrl`

## Requirements
- R1: After synchronous reset, `kernel_mode`=1, `irq_en`=0, `cause`=0, `epc`=0, and `redirect`, `flush` and `wb_kill` are all 0.
- R2: No fault is acted on before commit. An instruction presented at fetch before clock edge k reaches commit after edge k+3. `redirect` can rise no earlier than just after edge k+4.
- R3: Cause codes are 1 for an instruction address fault, 2 for an illegal opcode, 3 for an arithmetic overflow and 4 for a data address fault. When one instruction carries several faults, the code recorded is the one from the earliest stage.
- R4: An external interrupt is recognised only while `irq_en`=1 and a valid instruction is at commit. When recognised, it overrides every fault of that instruction and records cause 0.
- R5: On entry, `cause` takes the selected code and `epc` takes the PC of the committing instruction. Both values hold until the next entry.
- R6: On entry, `flush` and `wb_kill` pulse high for one cycle. Younger instructions in flight are discarded, and none of them can cause a later entry.
- R7: On entry, `redirect` pulses for one cycle with `redirect_pc`=HANDLER_PC, while `kernel_mode` becomes 1 and `irq_en` becomes 0.
- R8: A `rfe` pulse with no entry in the same cycle sets `irq_en`=1 and restores `kernel_mode` to the value it had just before the most recent entry. The value is 0 when there has been no entry since reset.
- R9: Bubbles (`if_valid`=0) carry no fault. Fault and interrupt inputs asserted while only bubbles are in flight never cause an entry.
- R10: An instruction with no fault and no recognised interrupt commits without an entry, and `cause` and `epc` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_valid | input | 1 | A real instruction enters fetch this cycle |
| if_pc | input | PCW | PC of the instruction entering fetch |
| if_fault | input | 1 | Instruction address fault for the entering instruction |
| id_illegal | input | 1 | Illegal opcode for the instruction now in decode |
| ex_ovf | input | 1 | Arithmetic overflow for the instruction now in execute |
| mem_fault | input | 1 | Data address fault for the instruction now at commit |
| ext_irq | input | 1 | External interrupt request, level |
| rfe | input | 1 | Return-from-exception pulse |
| redirect | output | 1 | One-cycle pulse: fetch must load `redirect_pc` |
| redirect_pc | output | PCW | Handler address |
| flush | output | 1 | One-cycle pulse: kill fetch, decode and execute |
| wb_kill | output | 1 | One-cycle pulse: suppress writeback of the faulting instruction |
| cause | output | 3 | Cause code of the latest entry |
| epc | output | PCW | PC of the instruction that took the latest entry |
| irq_en | output | 1 | Interrupt enable |
| kernel_mode | output | 1 | 1 in kernel mode, 0 in user mode |

## Verification
The hardest situation to reach from the ports is a single instruction that carries faults from several stages at once, possibly with an interrupt at commit on top. Each flag must be raised in exactly the cycle when that instruction occupies the matching stage. The bench walks a lone instruction through the pipe and drives each stage's flag one cycle later than the previous stage's. It sweeps all 32 combinations of the four faults and the interrupt, and computes the winning cause from the priority order. Killing of younger instructions is reached by placing a faulting instruction directly behind one that faults at commit.

// File: rtl/pexc_pkg.sv
package pexc_pkg;
  localparam int CAUSE_W = 3;
  typedef enum logic [CAUSE_W-1:0] {
    C_IRQ     = 3'd0,
    C_IFETCH  = 3'd1,
    C_ILLEGAL = 3'd2,
    C_OVF     = 3'd3,
    C_DADDR   = 3'd4
  } cause_e;
  localparam int NSTG = 4;  // fetch, decode, execute, memory
endpackage

// File: rtl/pexc_stage.sv
module pexc_stage
  import pexc_pkg::*;
#(
  parameter int     PCW  = 32,
  parameter cause_e CODE = C_IFETCH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           kill,
  input  logic           in_valid,
  input  logic [PCW-1:0] in_pc,
  input  logic           in_exc,
  input  cause_e         in_cause,
  input  logic           raise,
  output logic           valid,
  output logic [PCW-1:0] pc,
  output logic           exc,
  output cause_e         cause
);
  always_ff @(posedge clk) begin
    if (rst || kill) begin
      valid <= 1'b0;
      exc   <= 1'b0;
      pc    <= '0;
      cause <= C_IRQ;
    end else begin
      valid <= in_valid;
      pc    <= in_pc;
      if (in_valid) begin
        // an older flag is kept; this stage's flag only fills an empty slot
        exc   <= in_exc | raise;
        cause <= in_exc ? in_cause : CODE;
      end else begin
        exc   <= 1'b0;
        cause <= C_IRQ;
      end
    end
  end
endmodule

// File: rtl/pexc_commit.sv
module pexc_commit
  import pexc_pkg::*;
(
  input  logic   m_valid,
  input  logic   m_exc,
  input  cause_e m_cause,
  input  logic   mem_fault,
  input  logic   ext_irq,
  input  logic   irq_en,
  output logic   take,
  output cause_e sel_cause
);
  logic irq_ok;
  always_comb begin
    irq_ok = m_valid && ext_irq && irq_en;
    take   = m_valid && (m_exc || mem_fault || irq_ok);
    if (irq_ok)      sel_cause = C_IRQ;
    else if (m_exc)  sel_cause = m_cause;
    else             sel_cause = C_DADDR;
  end
endmodule

// File: rtl/pexc_state.sv
module pexc_state
  import pexc_pkg::*;
#(
  parameter int             PCW        = 32,
  parameter logic [PCW-1:0] HANDLER_PC = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  cause_e             sel_cause,
  input  logic [PCW-1:0]     m_pc,
  input  logic               rfe,
  output logic               redirect,
  output logic [PCW-1:0]     redirect_pc,
  output logic               flush,
  output logic               wb_kill,
  output logic [CAUSE_W-1:0] cause,
  output logic [PCW-1:0]     epc,
  output logic               irq_en,
  output logic               kernel_mode
);
  logic prev_kernel;

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect    <= 1'b0;
      redirect_pc <= '0;
      flush       <= 1'b0;
      wb_kill     <= 1'b0;
      cause       <= '0;
      epc         <= '0;
      irq_en      <= 1'b0;
      kernel_mode <= 1'b1;
      prev_kernel <= 1'b0;
    end else begin
      redirect <= take;
      flush    <= take;
      wb_kill  <= take;
      if (take) begin
        redirect_pc <= HANDLER_PC;
        cause       <= sel_cause;
        epc         <= m_pc;
        prev_kernel <= kernel_mode;
        irq_en      <= 1'b0;
        kernel_mode <= 1'b1;
      end else if (rfe) begin
        irq_en      <= 1'b1;
        kernel_mode <= prev_kernel;
      end
    end
  end
endmodule

// File: rtl/pexc_ctrl.sv
module pexc_ctrl
  import pexc_pkg::*;
#(
  parameter int             PCW        = 32,
  parameter logic [PCW-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               if_valid,
  input  logic [PCW-1:0]     if_pc,
  input  logic               if_fault,
  input  logic               id_illegal,
  input  logic               ex_ovf,
  input  logic               mem_fault,
  input  logic               ext_irq,
  input  logic               rfe,
  output logic               redirect,
  output logic [PCW-1:0]     redirect_pc,
  output logic               flush,
  output logic               wb_kill,
  output logic [CAUSE_W-1:0] cause,
  output logic [PCW-1:0]     epc,
  output logic               irq_en,
  output logic               kernel_mode
);
  function automatic cause_e code_of(input int i);
    case (i)
      2:       return C_ILLEGAL;
      3:       return C_OVF;
      default: return C_IFETCH;
    endcase
  endfunction

  logic           s_valid [0:NSTG];
  logic [PCW-1:0] s_pc    [0:NSTG];
  logic           s_exc   [0:NSTG];
  cause_e         s_cause [0:NSTG];
  logic           s_raise [0:NSTG-1];
  logic           take;
  cause_e         sel_cause;
  logic           m_valid;
  logic [PCW-1:0] m_pc;

  assign s_valid[0] = if_valid;
  assign s_pc[0]    = if_pc;
  assign s_exc[0]   = 1'b0;
  assign s_cause[0] = C_IFETCH;
  assign s_raise[0] = if_fault;
  assign s_raise[1] = 1'b0;
  assign s_raise[2] = id_illegal;
  assign s_raise[3] = ex_ovf;
  assign m_valid    = s_valid[NSTG];
  assign m_pc       = s_pc[NSTG];

  for (genvar i = 0; i < NSTG; i++) begin : g_stg
    pexc_stage #(.PCW(PCW), .CODE(code_of(i))) u_stg (
      .clk(clk), .rst(rst), .kill(take),
      .in_valid(s_valid[i]), .in_pc(s_pc[i]), .in_exc(s_exc[i]),
      .in_cause(s_cause[i]), .raise(s_raise[i]),
      .valid(s_valid[i+1]), .pc(s_pc[i+1]), .exc(s_exc[i+1]),
      .cause(s_cause[i+1])
    );
  end

  pexc_commit u_commit (
    .m_valid(m_valid), .m_exc(s_exc[NSTG]), .m_cause(s_cause[NSTG]),
    .mem_fault(mem_fault), .ext_irq(ext_irq), .irq_en(irq_en),
    .take(take), .sel_cause(sel_cause)
  );

  pexc_state #(.PCW(PCW), .HANDLER_PC(HANDLER_PC)) u_state (
    .clk(clk), .rst(rst), .take(take), .sel_cause(sel_cause), .m_pc(m_pc),
    .rfe(rfe), .redirect(redirect), .redirect_pc(redirect_pc),
    .flush(flush), .wb_kill(wb_kill), .cause(cause), .epc(epc),
    .irq_en(irq_en), .kernel_mode(kernel_mode)
  );
endmodule

// File: rtl/pexc_ctrl_chk.sv
module pexc_ctrl_chk #(
  parameter int PCW = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           m_valid,
  input logic [PCW-1:0] m_pc,
  input logic           take,
  input logic           redirect,
  input logic [2:0]     cause,
  input logic [PCW-1:0] epc,
  input logic           irq_en,
  input logic           kernel_mode,
  input logic           ext_irq,
  input logic           rfe
);
  p_commit_only_r2: assert property (@(posedge clk) disable iff (rst)
    redirect |-> $past(m_valid));
  p_irq_wins_r4: assert property (@(posedge clk) disable iff (rst)
    redirect && $past(ext_irq) && $past(irq_en) |-> cause == 3'd0);
  p_epc_r5: assert property (@(posedge clk) disable iff (rst)
    redirect |-> epc == $past(m_pc));
  p_flush_r6: assert property (@(posedge clk) disable iff (rst)
    take |=> !m_valid);
  p_entry_mode_r7: assert property (@(posedge clk) disable iff (rst)
    redirect |-> kernel_mode && !irq_en);
  p_rfe_r8: assert property (@(posedge clk) disable iff (rst)
    rfe && !take |=> irq_en);
  p_bubble_r9: assert property (@(posedge clk) disable iff (rst)
    !m_valid |-> !take);
endmodule

bind pexc_ctrl pexc_ctrl_chk #(.PCW(PCW)) u_chk (
  .clk(clk), .rst(rst), .m_valid(m_valid), .m_pc(m_pc), .take(take),
  .redirect(redirect), .cause(cause), .epc(epc), .irq_en(irq_en),
  .kernel_mode(kernel_mode), .ext_irq(ext_irq), .rfe(rfe)
);

// File: tb/pexc_ctrl_test.sv
module pexc_ctrl_test;
  localparam int             PCW = 16;
  localparam logic [PCW-1:0] HPC = 16'h0080;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic if_valid = 0, if_fault = 0, id_illegal = 0, ex_ovf = 0;
  logic mem_fault = 0, ext_irq = 0, rfe = 0;
  logic [PCW-1:0] if_pc = '0;
  logic redirect, flush, wb_kill, irq_en, kernel_mode;
  logic [PCW-1:0] redirect_pc, epc;
  logic [2:0] cause;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [2:0]     last_cause;
  logic [PCW-1:0] last_epc;

  always #10 clk = ~clk;

  pexc_ctrl #(.PCW(PCW), .HANDLER_PC(HPC)) uut (
    .clk(clk), .rst(rst), .if_valid(if_valid), .if_pc(if_pc),
    .if_fault(if_fault), .id_illegal(id_illegal), .ex_ovf(ex_ovf),
    .mem_fault(mem_fault), .ext_irq(ext_irq), .rfe(rfe),
    .redirect(redirect), .redirect_pc(redirect_pc), .flush(flush),
    .wb_kill(wb_kill), .cause(cause), .epc(epc), .irq_en(irq_en),
    .kernel_mode(kernel_mode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_rfe(input logic exp_kernel);
    @(negedge clk) rfe = 1;
    @(negedge clk) rfe = 0;
    check("R8 irq_en after rfe", irq_en, 1);
    check("R8 mode after rfe", kernel_mode, exp_kernel);
  endtask

  // one instruction walked alone through the pipe, each flag in its stage's cycle
  task automatic issue(input logic [PCW-1:0] pc, input bit f, d, e, m, irq);
    bit early;
    early = 0;
    @(negedge clk) begin if_valid = 1; if_pc = pc; if_fault = f; end
    @(negedge clk) begin if_valid = 0; if_fault = 0; early |= redirect; end
    @(negedge clk) begin id_illegal = d; early |= redirect; end
    @(negedge clk) begin id_illegal = 0; ex_ovf = e; early |= redirect; end
    @(negedge clk) begin ex_ovf = 0; mem_fault = m; ext_irq = irq; early |= redirect; end
    @(negedge clk) begin mem_fault = 0; ext_irq = 0; end
    check("R2 no redirect before commit", early, 0);
  endtask

  task automatic expect_entry(input string tag, input logic [2:0] c, input logic [PCW-1:0] pc);
    check({tag, " R7 redirect"}, redirect, 1);
    check({tag, " R7 handler pc"}, redirect_pc, HPC);
    check({tag, " R6 flush"}, flush, 1);
    check({tag, " R6 wb_kill"}, wb_kill, 1);
    check({tag, " R3/R4 cause"}, cause, c);
    check({tag, " R5 epc"}, epc, pc);
    check({tag, " R7 kernel"}, kernel_mode, 1);
    check({tag, " R7 irq off"}, irq_en, 0);
    last_cause = c;
    last_epc = pc;
    @(negedge clk);
    check({tag, " R7 redirect one cycle"}, redirect, 0);
  endtask

  task automatic expect_none(input string tag);
    check({tag, " R10 no redirect"}, redirect, 0);
    check({tag, " R10 cause held"}, cause, last_cause);
    check({tag, " R10 epc held"}, epc, last_epc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 kernel", kernel_mode, 1);
    check("R1 irq_en", irq_en, 0);
    check("R1 cause", cause, 0);
    check("R1 epc", epc, 0);
    check("R1 pulses", {redirect, flush, wb_kill}, 0);
    last_cause = 0;
    last_epc = 0;

    do_rfe(0);

    // sweep every fault combination with and without an enabled interrupt
    for (int k = 0; k < 32; k++) begin
      bit f, d, e, m, irq;
      logic [2:0] exp_c;
      logic [PCW-1:0] pc;
      f = k[0]; d = k[1]; e = k[2]; m = k[3]; irq = k[4];
      pc = 16'h1000 + 16'(k * 4);
      issue(pc, f, d, e, m, irq);
      if (irq)    exp_c = 3'd0;
      else if (f) exp_c = 3'd1;
      else if (d) exp_c = 3'd2;
      else if (e) exp_c = 3'd3;
      else        exp_c = 3'd4;
      if (f || d || e || m || irq) begin
        expect_entry("sweep", exp_c, pc);
        do_rfe(0);
      end else begin
        expect_none("sweep");
      end
    end

    // R4: interrupt ignored while disabled
    issue(16'h2000, 1, 0, 0, 0, 0);
    expect_entry("setup", 3'd1, 16'h2000);
    issue(16'h2004, 0, 0, 0, 0, 1);
    check("R4 irq masked no redirect", redirect, 0);
    check("R4 irq masked cause", cause, 3'd1);
    do_rfe(0);

    // R9: bubbles with every flag raised
    begin
      bit seen;
      seen = 0;
      @(negedge clk) begin if_valid = 0; if_fault = 1; id_illegal = 1; ex_ovf = 1; mem_fault = 1; ext_irq = 1; end
      repeat (6) @(negedge clk) seen |= redirect;
      if_fault = 0; id_illegal = 0; ex_ovf = 0; mem_fault = 0; ext_irq = 0;
      repeat (2) @(negedge clk) seen |= redirect;
      check("R9 bubbles never enter", seen, 0);
      check("R9 cause held", cause, last_cause);
    end

    // R6: younger faulting instruction is discarded by the older entry
    begin
      bit seen;
      seen = 0;
      @(negedge clk) begin if_valid = 1; if_pc = 16'h3000; if_fault = 0; end
      @(negedge clk) begin if_pc = 16'h3004; if_fault = 1; end
      @(negedge clk) begin if_valid = 0; if_fault = 0; end
      @(negedge clk);
      @(negedge clk) mem_fault = 1;
      @(negedge clk) mem_fault = 0;
      expect_entry("kill", 3'd4, 16'h3000);
      repeat (6) @(negedge clk) seen |= redirect;
      check("R6 younger never enters", seen, 0);
      check("R6 epc still older", epc, 16'h3000);
    end

    // R8: entry from kernel mode returns to kernel mode
    issue(16'h4000, 0, 0, 1, 0, 0);
    expect_entry("nest", 3'd3, 16'h4000);
    do_rfe(1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule